// File: doc/BRIEF.md
# PCM Short-Sync Serial Receiver

This block is the slave side of a PCM serial audio link. A remote master drives the bit clock, the frame strobe and the data line. The block oversamples all three with the local system clock and finds the one-bit-wide sync pulse. It then gathers the next sixteen data bits, most significant bit first, and hands the finished word to the system side.

In the intended use the link runs 256 bit periods per frame at 8 kHz, which is a 2.048 MHz bit clock. The system clock must run at least eight times faster than the bit clock. Each instance keeps its own synchroniser and state, so several copies can serve masters whose clocks are unrelated.

The output is a valid-only stream. The serial source cannot be stalled, so there is no ready input and no back-pressure. The consumer must take the word in the cycle in which `smp_valid` is high. If it misses that cycle, it can still read the word on `smp_data` until the next word completes.

Top module: `pcm_sync_rx`

## Requirements
- R1: While reset is asserted and just after it is released, `smp_valid` is 0, `smp_data` is 16'h0000 and `frame_err` is 0.
- R2: Data is captured only at falling edges of `pcm_bclk`. A change on `pcm_din` during the low phase, after a falling edge, does not alter the captured bit.
- R3: A frame starts at the falling edge at which `pcm_fsync` is seen high. The bit captured at the next falling edge is the MSB (bit 15), and bits 14 down to 0 follow on the 15 falling edges after it.
- R4: When bit 0 has been captured, `smp_valid` is high for exactly one system clock, and `smp_data` then carries the assembled word.
- R5: `smp_data` keeps its value until the next word completes, including during the first 15 bits of the following frame.
- R6: After bit 0, the remaining bit periods of the frame are ignored until the next sync pulse. They produce no extra `smp_valid` and do not change `smp_data`.
- R7: If a sync pulse is seen while a word is still being gathered, the partial word is discarded without a `smp_valid`, and gathering restarts from that pulse.
- R8: `frame_err` is set by the event in R7, stays 1 through later good frames, and is cleared only by reset.
- R9: If the sync pulse falls on the edge that would have carried bit 0, the sync takes priority. No word is delivered, `frame_err` is set, and a new word is gathered from that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcm_bclk | input | 1 | Bit clock from the external master |
| pcm_fsync | input | 1 | One-bit-wide frame sync from the master |
| pcm_din | input | 1 | Serial data, launched by the master on rising edges |
| smp_data | output | 16 | Most recent completed word |
| smp_valid | output | 1 | One-cycle strobe marking a new word |
| frame_err | output | 1 | Sticky flag: sync arrived while a word was still incomplete |

## Verification
Two functions can fall on the same falling edge: capturing the last bit of a word and restarting on a sync pulse. The bench provokes this by sending fifteen bits of one word and then a sync pulse in the sixteenth bit slot. The result is judged correct when no strobe appears for the abandoned word, the error flag rises, and the next word arrives intact. A second overlap is a data change during the low phase shortly after a falling edge; the captured words must stay correct despite it.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_SHIFT = 1'b1
  } rx_state_e;
endpackage

// File: rtl/pcm_rx_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit inputs.
module pcm_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/pcm_rx_edge.sv
// Finds falling edges of the synchronised bit clock.
module pcm_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_s,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= bclk_s;
  end

  assign fall = prev & ~bclk_s;
endmodule

// File: rtl/pcm_rx_deser.sv
// Sync-locked shifter: gathers one word after each sync pulse.
module pcm_rx_deser
  import pcm_rx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              fs_bit,
  input  logic              d_bit,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld,
  output logic              err_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] nxt;

  assign nxt = {shreg[WORD_W-2:0], d_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      word_o   <= '0;
      word_vld <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (bit_stb) begin
        if (fs_bit) begin
          if (state == RX_SHIFT) err_o <= 1'b1;
          state <= RX_SHIFT;
          cnt   <= '0;
        end else if (state == RX_SHIFT) begin
          shreg <= nxt;
          if (cnt == LAST) begin
            word_o   <= nxt;
            word_vld <= 1'b1;
            state    <= RX_IDLE;
            cnt      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld); // R4
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> $stable(word_o)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R8
  AST_NO_SHIFT_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(cnt) && $stable(shreg)); // R2
  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && fs_bit) |=> (state == RX_SHIFT && cnt == '0 && !word_vld)); // R7
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE && !word_vld) |=> !word_vld); // R6
endmodule

// File: rtl/pcm_sync_rx.sv
module pcm_sync_rx #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pcm_bclk,
  input  logic              pcm_fsync,
  input  logic              pcm_din,
  output logic [WORD_W-1:0] smp_data,
  output logic              smp_valid,
  output logic              frame_err
);
  logic [2:0] raw_in;
  logic [2:0] syn;
  logic       fall;

  assign raw_in = {pcm_bclk, pcm_fsync, pcm_din};

  pcm_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_in),
    .dout (syn)
  );

  pcm_rx_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .bclk_s(syn[2]),
    .fall  (fall)
  );

  pcm_rx_deser #(.WORD_W(WORD_W)) u_deser (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_stb (fall),
    .fs_bit  (syn[1]),
    .d_bit   (syn[0]),
    .word_o  (smp_data),
    .word_vld(smp_valid),
    .err_o   (frame_err)
  );
endmodule

// File: tb/pcm_sync_rx_test.sv
module pcm_sync_rx_test;
  localparam int HALF   = 4;
  localparam int FRAME  = 256;
  localparam int NWORDS = 6;
  localparam logic [15:0] WORDS [NWORDS] =
    '{16'h8001, 16'hA5C3, 16'h0000, 16'hFFFF, 16'h7FFE, 16'h1234};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, din = 1'b0;
  logic [15:0] smp_data;
  logic smp_valid, frame_err;

  int errors = 0, checks = 0, vcnt = 0;
  logic [15:0] last_word = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcm_sync_rx uut (
    .clk(clk), .rst_n(rst_n), .pcm_bclk(bclk), .pcm_fsync(fsync),
    .pcm_din(din), .smp_data(smp_data), .smp_valid(smp_valid),
    .frame_err(frame_err)
  );

  always @(negedge clk) if (smp_valid) begin
    vcnt++;
    last_word = smp_data;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bit period: launch on rise, disturb data shortly after the fall.
  task automatic send_bit(input logic fs, input logic d);
    @(negedge clk);
    bclk = 1'b1; fsync = fs; din = d;
    repeat (HALF) @(negedge clk);
    bclk = 1'b0;
    repeat (3) @(negedge clk);
    din = ~d;
    repeat (HALF - 3) @(negedge clk);
  endtask

  task automatic word_bits(input logic [15:0] w, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) send_bit(1'b0, w[i]);
  endtask

  task automatic tail(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0, 1'($urandom_range(0, 1)));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v0;
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    // R1: state during reset and right after release
    chk(smp_valid == 1'b0, "R1 valid in reset", smp_valid, 0);
    do_reset();
    chk(smp_data == 16'h0, "R1 data after reset", smp_data, 0);
    chk(frame_err == 1'b0, "R1 err after reset", frame_err, 0);
    chk(vcnt == 0, "R1 no strobe after reset", vcnt, 0);

    // Vector table: each word sent in a full 256-bit frame
    prev = 16'h0;
    for (int k = 0; k < NWORDS; k++) begin
      v0 = vcnt;
      send_bit(1'b1, 1'b0);
      word_bits(WORDS[k], 15, 1);
      chk(smp_data == prev && vcnt == v0, "R5 word held mid-frame", smp_data, prev);
      word_bits(WORDS[k], 0, 0);
      tail(FRAME - 17);
      chk(vcnt == v0 + 1, "R4 R6 one strobe per frame", vcnt - v0, 1);
      chk(last_word == WORDS[k], "R3 R2 captured word", last_word, WORDS[k]);
      chk(smp_data == WORDS[k], "R6 data unchanged by tail", smp_data, WORDS[k]);
      chk(frame_err == 1'b0, "R8 no error on clean frames", frame_err, 0);
      prev = WORDS[k];
    end

    // R7/R8: early sync after 5 bits discards the partial word
    v0 = vcnt;
    send_bit(1'b1, 1'b0);
    word_bits(16'hFFFF, 15, 11);
    send_bit(1'b1, 1'b0);
    word_bits(16'h3C5A, 15, 0);
    tail(FRAME - 23);
    chk(vcnt == v0 + 1, "R7 partial word dropped", vcnt - v0, 1);
    chk(smp_data == 16'h3C5A, "R7 restarted word", smp_data, 16'h3C5A);
    chk(frame_err == 1'b1, "R8 error set", frame_err, 1);
    v0 = vcnt;
    send_bit(1'b1, 1'b0);
    word_bits(16'h0F0F, 15, 0);
    tail(FRAME - 17);
    chk(frame_err == 1'b1, "R8 error sticky", frame_err, 1);
    chk(smp_data == 16'h0F0F && vcnt == v0 + 1, "R8 good frame after error", smp_data, 16'h0F0F);

    // R8 cleared only by reset; R9 sync in the bit-0 slot
    do_reset();
    chk(frame_err == 1'b0, "R8 error cleared by reset", frame_err, 0);
    v0 = vcnt;
    send_bit(1'b1, 1'b0);
    word_bits(16'hDEAD, 15, 1);
    send_bit(1'b1, 1'b0);
    chk(vcnt == v0, "R9 no strobe for abandoned word", vcnt - v0, 0);
    word_bits(16'hBEEF, 15, 0);
    tail(FRAME - 34);
    chk(vcnt == v0 + 1, "R9 one strobe total", vcnt - v0, 1);
    chk(smp_data == 16'hBEEF, "R9 next word intact", smp_data, 16'hBEEF);
    chk(frame_err == 1'b1, "R9 error set", frame_err, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule